// File: doc/BRIEF.md
# Shared-Mailbox Command Handler

This block is a host-to-device command mailbox of eight 32-bit words, which makes 32 bytes. The host first writes the parameter words 0 to 6. It then writes a header into word 7. A write that touches any byte of the header starts processing at once. The handler decodes the header's type, version and response flag, runs the command, and writes a completion back into the header word. The host polls that word to see the result.

Three commands exist:

- An establish command brings up a control channel. It unpacks four queue page numbers and an interrupt vector from the packed parameter words and converts each page number into a byte base address. It then pulses a start request toward the channel logic.
- A destroy command raises a stop request and leaves the header untouched. It completes only on a later mailbox read, made while the channel logic acknowledges the stop.
- A timeout report carries diagnostic fields. The handler accepts it and completes it with success.

Top module: `mbx_cmd_handler`

## Requirements
- R1: A write with any byte strobe set to word 7 (byte offsets 28 to 31) is merged byte-wise into the header and starts processing. Writes to words 0 to 6, and a write to word 7 with no strobe set, only store data (or do nothing) and leave the header unchanged.
- R2: The header holds the type in bits 7:0, the version in bits 15:8, a response flag in bit 16 and a status in bits 31:24. A completion sets bit 16 and writes the status (0 for success, 1 for error) and keeps bits 23:0 as written.
- R3: A header whose response flag is already set completes with status 1, whatever its type.
- R4: Establish (type 0x01) succeeds only when its version equals 1 and the channel is inactive. On success it completes with status 0, sets chan_active, and pulses chan_start high for exactly one cycle. In every other case it completes with status 1.
- R5: On a successful establish, four 52-bit page numbers are formed and each is multiplied by 4096 to give a base address.
  - The low 48 bits of each come from little-endian bytes at mailbox offsets 0, 6, 12 and 18 for the event, completion, receive and send queues.
  - Bits 51:48 come from word 6 bits 3:0, 7:4, 11:8 and 15:12 respectively.
  - The base outputs change only on a successful establish.
- R6: On a successful establish, chan_vector takes word 6 bits 31:16.
- R7: Destroy (type 0x02) with version exactly 1 raises chan_stop_req and leaves the header unchanged with no completion. With any other version it completes with status 1.
- R8: While a destroy is pending, a mailbox read made while stop_ack is high completes the destroy. In that cycle the header gets status 0 with the response flag set, chan_active and chan_stop_req clear, and the read returns the completed value. A read made while stop_ack is low changes nothing.
- R9: A timeout report (type 0x03) with version 1 or higher completes with status 0. A lower version completes with status 1.
- R10: Any other type value completes with status 1.
- R11: While a destroy is pending, writes to word 7 are ignored, and parameter words remain writable.
- R12: rd_data shows, one cycle after rd_en, the addressed word as it stands after that clock edge, including any write or completion made at the same edge. All state resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Word index of the write |
| wr_strb | input | 4 | Byte strobes of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Word index of the read |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| stop_ack | input | 1 | Channel logic has stopped |
| chan_start | output | 1 | One-cycle start request for the control channel |
| chan_stop_req | output | 1 | Stop request, held while a destroy is pending |
| chan_active | output | 1 | Control channel established |
| chan_vector | output | 16 | Interrupt vector of the channel |
| eq_base | output | 64 | Event queue base address |
| cq_base | output | 64 | Completion queue base address |
| rq_base | output | 64 | Receive queue base address |
| sq_base | output | 64 | Send queue base address |

## Verification
The case that needs the most care is a destroy completion and a header write landing on the same clock edge. The bench sets up a pending destroy and raises stop_ack. In one cycle it then issues a read of the header together with a new establish write to the header. The read must return the destroy completion (status 0), the write must be dropped, and the channel must go inactive. A second header read must show the same value. A later case merges a single-byte header write onto a completed header that still carries its response flag, which must come back as an error.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned WORDS   = 8;
    localparam int unsigned IDX_W   = $clog2(WORDS);
    localparam int unsigned STRB_W  = WORD_W / 8;
    localparam int unsigned HDR_IDX = WORDS - 1;
    localparam int unsigned PRM_W   = HDR_IDX * WORD_W;
    localparam int unsigned NQ      = 4;
    localparam int unsigned LO_W    = 48;
    localparam int unsigned HI_W    = 4;
    localparam int unsigned PN_W    = LO_W + HI_W;
    localparam int unsigned VEC_W   = 16;
    localparam int unsigned RESP_BIT = 16;

    typedef enum logic [1:0] {
        K_ERR,
        K_OK,
        K_EST,
        K_DES
    } cmd_kind_e;

    function automatic logic [WORD_W-1:0] finish_hdr(input logic [WORD_W-1:0] h,
                                                     input logic err);
        return {7'd0, err, h[23:17], 1'b1, h[15:0]};
    endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter logic [7:0] TYPE_EST    = 8'h01,
    parameter logic [7:0] TYPE_DES    = 8'h02,
    parameter logic [7:0] TYPE_TMO    = 8'h03,
    parameter logic [7:0] VER_EST     = 8'd1,
    parameter logic [7:0] VER_DES     = 8'd1,
    parameter logic [7:0] VER_TMO_MIN = 8'd1
) (
    input  logic [RESP_BIT:0] hdr,
    input  logic              active,
    output cmd_kind_e         kind
);
    logic [7:0] mtype;
    logic [7:0] mver;

    assign mtype = hdr[7:0];
    assign mver  = hdr[15:8];

    always_comb begin
        kind = K_ERR;
        if (!hdr[RESP_BIT]) begin
            if (mtype == TYPE_EST) begin
                kind = (mver == VER_EST && !active) ? K_EST : K_ERR;
            end else if (mtype == TYPE_DES) begin
                kind = (mver == VER_DES) ? K_DES : K_ERR;
            end else if (mtype == TYPE_TMO) begin
                kind = (mver >= VER_TMO_MIN) ? K_OK : K_ERR;
            end
        end
    end
endmodule

// File: rtl/mbx_unpack.sv
module mbx_unpack
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input  logic [PRM_W-1:0]             prm,
    output logic [NQ-1:0][ADDR_W-1:0]    base,
    output logic [VEC_W-1:0]             vector
);
    localparam int unsigned SHARED_LSB = (HDR_IDX - 1) * WORD_W;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
        assign lo = prm[LO_W*q +: LO_W];
        assign hi = prm[SHARED_LSB + HI_W*q +: HI_W];
        assign base[q] = ADDR_W'({hi, lo}) << PAGE_SHIFT;
    end

    assign vector = prm[SHARED_LSB + NQ*HI_W +: VEC_W];
endmodule

// File: rtl/mbx_cmd_handler.sv
module mbx_cmd_handler
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned PAGE_SHIFT  = 12,
    parameter logic [7:0]  TYPE_EST    = 8'h01,
    parameter logic [7:0]  TYPE_DES    = 8'h02,
    parameter logic [7:0]  TYPE_TMO    = 8'h03,
    parameter logic [7:0]  VER_EST     = 8'd1,
    parameter logic [7:0]  VER_DES     = 8'd1,
    parameter logic [7:0]  VER_TMO_MIN = 8'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [3:0]        wr_strb,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic              stop_ack,
    output logic              chan_start,
    output logic              chan_stop_req,
    output logic              chan_active,
    output logic [15:0]       chan_vector,
    output logic [ADDR_W-1:0] eq_base,
    output logic [ADDR_W-1:0] cq_base,
    output logic [ADDR_W-1:0] rq_base,
    output logic [ADDR_W-1:0] sq_base
);
    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mbx;
        logic [WORD_W-1:0]            rdat;
        logic                         active;
        logic                         pending;
        logic                         start;
        logic [NQ-1:0][ADDR_W-1:0]    base;
        logic [VEC_W-1:0]             vector;
    } state_t;

    state_t s_d, s_q;

    logic [WORD_W-1:0]         merged;
    logic                      any_wr;
    logic                      hdr_wr;
    logic                      des_done;
    cmd_kind_e                 kind;
    logic [NQ-1:0][ADDR_W-1:0] unp_base;
    logic [VEC_W-1:0]          unp_vec;
    logic [PRM_W-1:0]          prm;

    always_comb begin
        for (int b = 0; b < STRB_W; b++) begin
            merged[8*b +: 8] = wr_strb[b] ? wr_data[8*b +: 8] : s_q.mbx[wr_addr][8*b +: 8];
        end
    end

    assign any_wr   = wr_en && (wr_strb != '0);
    assign hdr_wr   = any_wr && (wr_addr == IDX_W'(HDR_IDX));
    assign des_done = rd_en && s_q.pending && stop_ack;
    assign prm      = s_q.mbx[HDR_IDX-1:0];

    mbx_decode #(
        .TYPE_EST(TYPE_EST), .TYPE_DES(TYPE_DES), .TYPE_TMO(TYPE_TMO),
        .VER_EST(VER_EST), .VER_DES(VER_DES), .VER_TMO_MIN(VER_TMO_MIN)
    ) u_decode (
        .hdr    (merged[RESP_BIT:0]),
        .active (s_q.active),
        .kind   (kind)
    );

    mbx_unpack #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
    ) u_unpack (
        .prm    (prm),
        .base   (unp_base),
        .vector (unp_vec)
    );

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (any_wr && !(hdr_wr && s_q.pending)) begin
            s_d.mbx[wr_addr] = merged;
        end
        if (hdr_wr && !s_q.pending) begin
            case (kind)
                K_ERR: s_d.mbx[HDR_IDX] = finish_hdr(merged, 1'b1);
                K_OK:  s_d.mbx[HDR_IDX] = finish_hdr(merged, 1'b0);
                K_EST: begin
                    s_d.mbx[HDR_IDX] = finish_hdr(merged, 1'b0);
                    s_d.active       = 1'b1;
                    s_d.start        = 1'b1;
                    s_d.base         = unp_base;
                    s_d.vector       = unp_vec;
                end
                default: s_d.pending = 1'b1;
            endcase
        end
        if (des_done) begin
            s_d.mbx[HDR_IDX] = finish_hdr(s_q.mbx[HDR_IDX], 1'b0);
            s_d.pending      = 1'b0;
            s_d.active       = 1'b0;
        end
        if (rd_en) begin
            s_d.rdat = s_d.mbx[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data       = s_q.rdat;
    assign chan_start    = s_q.start;
    assign chan_stop_req = s_q.pending;
    assign chan_active   = s_q.active;
    assign chan_vector   = s_q.vector;
    assign eq_base       = s_q.base[0];
    assign cq_base       = s_q.base[1];
    assign rq_base       = s_q.base[2];
    assign sq_base       = s_q.base[3];

    a_r4_start_with_active: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start |-> chan_active);
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start |=> !chan_start);
    a_r7_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
        chan_stop_req && !(rd_en && stop_ack) |=> chan_stop_req);
    a_r8_destroy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && chan_stop_req && stop_ack |=> !chan_active && !chan_stop_req);
    a_r11_hdr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        chan_stop_req && !rd_en |=> $stable(s_q.mbx[HDR_IDX]));
    a_r2_resp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wr && !chan_stop_req && kind != K_DES |=> s_q.mbx[HDR_IDX][RESP_BIT]);
endmodule

// File: tb/tb_mbx_cmd_handler.sv
module tb_mbx_cmd_handler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        stop_ack = 1'b0;
    logic        chan_start, chan_stop_req, chan_active;
    logic [15:0] chan_vector;
    logic [63:0] eq_base, cq_base, rq_base, sq_base;

    always #4 clk = ~clk;

    mbx_cmd_handler dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .stop_ack(stop_ack),
        .chan_start(chan_start), .chan_stop_req(chan_stop_req), .chan_active(chan_active),
        .chan_vector(chan_vector),
        .eq_base(eq_base), .cq_base(cq_base), .rq_base(rq_base), .sq_base(sq_base)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m [8];
    bit          m_act, m_pend, m_start;
    logic [31:0] m_rd;
    logic [63:0] m_base [4];
    logic [15:0] m_vec;

    function automatic logic [31:0] complete(input logic [31:0] h, input int st);
        logic [31:0] r;
        r = h;
        r[16] = 1'b1;
        r[31:24] = 8'(st);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m[i]) m[i] = 0;
            m_act = 0; m_pend = 0; m_start = 0; m_rd = 0; m_vec = 0;
            foreach (m_base[i]) m_base[i] = 0;
        end else begin
            logic [31:0] nw;
            int ty, ve;
            m_start = 0;
            nw = m[wr_addr];
            for (int b = 0; b < 4; b++) if (wr_strb[b]) nw[8*b +: 8] = wr_data[8*b +: 8];
            if (wr_en && wr_strb != 0) begin
                if (wr_addr != 7) m[wr_addr] = nw;
                else if (!m_pend) begin
                    ty = int'(nw[7:0]);
                    ve = int'(nw[15:8]);
                    if (nw[16]) m[7] = complete(nw, 1);
                    else if (ty == 1) begin
                        if (ve == 1 && !m_act) begin
                            logic [7:0] by [32];
                            for (int k = 0; k < 32; k++) by[k] = m[k/4][8*(k%4) +: 8];
                            for (int q = 0; q < 4; q++) begin
                                logic [63:0] pn;
                                pn = 0;
                                for (int k = 0; k < 6; k++) pn = pn | (64'(by[6*q+k]) << (8*k));
                                pn = pn | (64'((m[6] >> (4*q)) & 32'hF) << 48);
                                m_base[q] = pn * 4096;
                            end
                            m_vec = m[6][31:16];
                            m_act = 1; m_start = 1;
                            m[7] = complete(nw, 0);
                        end else m[7] = complete(nw, 1);
                    end else if (ty == 2) begin
                        if (ve == 1) begin m[7] = nw; m_pend = 1; end
                        else m[7] = complete(nw, 1);
                    end else if (ty == 3) m[7] = complete(nw, ve >= 1 ? 0 : 1);
                    else m[7] = complete(nw, 1);
                end
            end
            if (rd_en && m_pend && stop_ack) begin
                m[7] = complete(m[7], 0);
                m_pend = 0; m_act = 0;
            end
            if (rd_en) m_rd = m[rd_addr];
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R12 rd_data", 64'(rd_data), 64'(m_rd));
            check("R4 chan_start", 64'(chan_start), 64'(m_start));
            check("R4 chan_active", 64'(chan_active), 64'(m_act));
            check("R7 chan_stop_req", 64'(chan_stop_req), 64'(m_pend));
            check("R5 eq_base", eq_base, m_base[0]);
            check("R5 cq_base", cq_base, m_base[1]);
            check("R5 rq_base", rq_base, m_base[2]);
            check("R5 sq_base", sq_base, m_base[3]);
            check("R6 chan_vector", 64'(chan_vector), 64'(m_vec));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 0; wr_strb = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        v = rd_data;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12 reset rd_data", 64'(rd_data), 0);
        check("R12 reset active", 64'(chan_active), 0);

        wr(0, 32'h89AB_CDEF); wr(1, 32'h4567_0123); wr(2, 32'h1111_2222);
        wr(3, 32'h3333_4444); wr(4, 32'h5555_6666); wr(5, 32'h7777_8888);
        wr(6, 32'hBEEF_4321);
        rd(2, v); check("R12 param readback", 64'(v), 64'h1111_2222);
        rd(7, v); check("R1 param writes leave header", 64'(v), 0);
        wr(7, 32'hFFFF_FFFF, 4'h0);
        rd(7, v); check("R1 zero-strobe write ignored", 64'(v), 0);

        wr(7, 32'h0000_0101);
        check("R4 start pulse", 64'(chan_start), 1);
        rd(7, v); check("R2 establish completion", 64'(v), 64'h0001_0101);
        check("R4 active", 64'(chan_active), 1);
        check("R5 eq base", eq_base, 64'h1012_389A_BCDE_F000);
        check("R5 cq base", cq_base, 64'h2111_1222_2456_7000);
        check("R6 vector", 64'(chan_vector), 64'hBEEF);

        wr(7, 32'h0000_0101);
        rd(7, v); check("R4 establish while active", 64'(v), 64'h0101_0101);
        wr(7, 32'h0001_0003);
        rd(7, v); check("R3 response flag preset", 64'(v), 64'h0101_0003);
        wr(7, 32'h0000_0203);
        rd(7, v); check("R9 timeout higher version", 64'(v), 64'h0001_0203);
        wr(7, 32'h0000_0003);
        rd(7, v); check("R9 timeout low version", 64'(v), 64'h0101_0003);
        wr(7, 32'h0000_0155);
        rd(7, v); check("R10 unknown type", 64'(v), 64'h0101_0155);
        wr(7, 32'h0000_0202);
        rd(7, v); check("R7 destroy bad version", 64'(v), 64'h0101_0202);

        wr(7, 32'h0000_0102);
        check("R7 stop request", 64'(chan_stop_req), 1);
        rd(7, v); check("R7 destroy header untouched", 64'(v), 64'h0000_0102);
        check("R8 no ack keeps active", 64'(chan_active), 1);
        wr(7, 32'h0000_0103);
        wr(7, 32'h0000_00FF, 4'h1);
        rd(7, v); check("R11 header write ignored", 64'(v), 64'h0000_0102);
        wr(5, 32'hCAFE_F00D);
        rd(5, v); check("R11 param still writable", 64'(v), 64'hCAFE_F00D);

        @(negedge clk);
        stop_ack = 1;
        rd_en = 1; rd_addr = 7;
        wr_en = 1; wr_addr = 7; wr_strb = 4'hF; wr_data = 32'h0000_0101;
        @(negedge clk);
        rd_en = 0; wr_en = 0; wr_strb = 0; stop_ack = 0;
        check("R8 completion on same-cycle read", 64'(rd_data), 64'h0001_0102);
        check("R8 active cleared", 64'(chan_active), 0);
        check("R8 stop dropped", 64'(chan_stop_req), 0);
        rd(7, v); check("R11 same-cycle write dropped", 64'(v), 64'h0001_0102);

        wr(7, 32'h0000_0300, 4'h2);
        rd(7, v); check("R1 byte-lane merge triggers", 64'(v), 64'h0101_0302);
        wr(7, 32'h0000_0101);
        rd(7, v); check("R4 re-establish", 64'(v), 64'h0001_0101);
        check("R5 sq base new params", sq_base, 64'h4CAF_EF00_D555_5000);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule